// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Status Queue

This block receives serial character frames on a single data line and queues each finished character, together with its own status, for a host-side reader. In asynchronous mode it runs its own baud divider at sixteen ticks per bit. It confirms a falling edge as a start bit at mid-bit, then samples each later bit at its centre. In clock-synchronous mode it takes one bit on each selected edge of an external serial clock. Data arrives least significant bit first. The character length can be five to nine bits, followed by an optional parity bit and one or more stop bits. Only the first stop bit is examined.

Each finished character is written into a small FIFO. An entry holds the low data byte, the ninth data bit, and the frame-error, parity-error and overrun flags that belong to that character. The read side shows the head entry at all times. Pulsing the pop input is the read of the low data byte: it removes the data and all of its status in one step. The reader must therefore collect the ninth bit and the flags before it pops.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: In asynchronous mode a low level seen after the line was high starts a frame only if the line is still low at mid-bit, eight ticks later. If it is high again, the receiver returns to idle and queues nothing.
- R2: In asynchronous mode one bit lasts 16*(baud_div+1) clock cycles. Characters are received correctly for different baud_div values.
- R3: char_size selects the number of data bits: 3'b000=5, 3'b001=6, 3'b010=7, 3'b111=9, and any other code=8. Bits arrive LSB first, and the unused upper bits of rd_data read 0.
- R4: With char_size=3'b111 the ninth received data bit appears on rd_bit9, and the first eight bits appear on rd_data. In every other size rd_bit9 reads 0.
- R5: parity_mode 2'b10 expects even parity and 2'b11 expects odd parity over the data bits plus the parity bit. The parity bit follows the data MSB. A mismatch sets rd_parity_err for that character. With 2'b00 or 2'b01 no parity bit is expected.
- R6: A low first stop bit sets rd_frame_err for that character. A second stop bit is never examined, and a later low line does not start a new frame until the line has been high.
- R7: Characters leave the queue in arrival order. rd_valid is high while the queue holds an entry. A pop removes the head entry with all of its flags. A pop on an empty queue has no effect, and all rd_ outputs read 0 while the queue is empty.
- R8: A character that completes while the queue is full is dropped, and rd_overrun is set on the newest stored entry. Earlier entries keep their contents.
- R9: In synchronous mode one bit is taken on each rising edge of sclk_in (sclk_edge_sel=0) or each falling edge (sclk_edge_sel=1). A low bit at such an edge is the start bit.
- R10: While rx_en is low the receiver stays idle and queues nothing. The queue can still be read.
- R11: After reset the queue is empty and every rd_ output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| sync_mode | input | 1 | 0 = asynchronous, 1 = clock-synchronous |
| sclk_edge_sel | input | 1 | Synchronous sampling edge: 0 rising, 1 falling |
| sclk_in | input | 1 | External serial clock (synchronous mode) |
| rxd_in | input | 1 | Serial data line, idle high |
| char_size | input | 3 | Character length code |
| parity_mode | input | 2 | Parity check mode |
| baud_div | input | DIV_W | Tick divider; tick period is baud_div+1 cycles |
| rd_pop | input | 1 | Read of the low data byte; pops the head entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 8 | Head entry low data byte |
| rd_bit9 | output | 1 | Head entry ninth data bit |
| rd_frame_err | output | 1 | Head entry frame error |
| rd_parity_err | output | 1 | Head entry parity error |
| rd_overrun | output | 1 | Head entry overrun flag |

## Verification
The assertions assume that char_size, parity_mode, sync_mode and sclk_edge_sel do not change while a frame is in flight. They also assume that in synchronous mode each half-period of sclk_in is longer than the synchronizer delay, so every selected edge is seen once. The stimulus changes settings only while the line is idle and the queue has settled. It holds every asynchronous bit for a full bit period. In synchronous mode it changes rxd_in only on the non-sampling edge, eight clocks before the sampling edge. A cycle-level queue model in the bench is compared with the read port on every clock while no frame or pop is in progress.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       bit9;
      logic       ferr;
      logic       perr;
   } rx_char_t;

   function automatic logic [3:0] char_bits(input logic [2:0] code);
      case (code)
         3'b000:  return 4'd5;
         3'b001:  return 4'd6;
         3'b010:  return 4'd7;
         3'b111:  return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int         W       = 2,
   parameter int         STAGES  = 2,
   parameter logic [1:0] RST_VAL = 2'b11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uart_rx_sync: STAGES must be at least 2");
   end
   if (W > 2) begin : g_bad_width
      $error("uart_rx_sync: W must be 1 or 2");
   end

   localparam logic [W-1:0] RV = RST_VAL[W-1:0];

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RV;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RV;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   if (DIV_W < 2) begin : g_bad_div
      $error("uart_rx_baud: DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= div) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end

   // R2: with a divider above zero, ticks never come on back-to-back cycles
   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame import uart_rx_pkg::*; #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       sync_mode,
   input  logic       tick,
   input  logic       strobe,
   input  logic       line,
   input  logic [2:0] char_size,
   input  logic [1:0] parity_mode,
   output logic       push,
   output rx_char_t   char_o
);
   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("uart_rx_frame: OVS must be a power of two, at least 4");
   end

   localparam int           CW   = $clog2(OVS);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   rx_state_e     state_q;
   logic [CW-1:0] cnt_q;
   logic [3:0]    bidx_q;
   logic [8:0]    shreg_q;
   logic          par_acc_q;
   logic          perr_q;
   logic          prev_hi_q;
   logic [3:0]    nbits;
   logic          par_on;
   logic          samp;

   assign nbits  = char_bits(char_size);
   assign par_on = parity_mode[1];
   assign samp   = sync_mode ? strobe : (tick && cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         cnt_q     <= '0;
         bidx_q    <= '0;
         shreg_q   <= '0;
         par_acc_q <= 1'b0;
         perr_q    <= 1'b0;
         prev_hi_q <= 1'b0;
         push      <= 1'b0;
         char_o    <= '0;
      end else begin
         push <= 1'b0;
         if (tick) prev_hi_q <= line;
         if (!en) begin
            state_q <= RX_IDLE;
         end else begin
            case (state_q)
               RX_IDLE: begin
                  cnt_q     <= '0;
                  bidx_q    <= '0;
                  shreg_q   <= '0;
                  par_acc_q <= 1'b0;
                  perr_q    <= 1'b0;
                  if (sync_mode) begin
                     if (strobe && !line) state_q <= RX_DATA;
                  end else if (tick && prev_hi_q && !line) begin
                     state_q <= RX_START;
                  end
               end
               RX_START: begin
                  if (tick) begin
                     if (cnt_q == MID) begin
                        cnt_q   <= '0;
                        state_q <= line ? RX_IDLE : RX_DATA;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               RX_DATA: begin
                  if (!sync_mode && tick) cnt_q <= cnt_q + 1'b1;
                  if (samp) begin
                     shreg_q[bidx_q] <= line;
                     par_acc_q       <= par_acc_q ^ line;
                     bidx_q          <= bidx_q + 4'd1;
                     if (bidx_q == nbits - 4'd1)
                        state_q <= par_on ? RX_PAR : RX_STOP;
                  end
               end
               RX_PAR: begin
                  if (!sync_mode && tick) cnt_q <= cnt_q + 1'b1;
                  if (samp) begin
                     perr_q  <= (par_acc_q ^ line) != parity_mode[0];
                     state_q <= RX_STOP;
                  end
               end
               RX_STOP: begin
                  if (!sync_mode && tick) cnt_q <= cnt_q + 1'b1;
                  if (samp) begin
                     push        <= 1'b1;
                     char_o.data <= shreg_q[7:0];
                     char_o.bit9 <= (nbits == 4'd9) & shreg_q[8];
                     char_o.ferr <= !line;
                     char_o.perr <= perr_q;
                     state_q     <= RX_IDLE;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R1: a start that is high again at mid-bit is abandoned without a push
   p_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sync_mode && state_q == RX_START && tick && cnt_q == MID && line)
      |=> (state_q == RX_IDLE && !push));

   // R10: disabled receiver stays idle and never pushes
   p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state_q == RX_IDLE && !push));

   // R6: a character is pushed only out of the first stop bit
   p_push_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> $past(state_q) == RX_STOP);

   // R5: the parity slot is only visited when parity checking is on
   p_parity_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_PAR) |-> parity_mode[1]);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo import uart_rx_pkg::*; #(
   parameter int DEPTH = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  rx_char_t wdata,
   input  logic     pop,
   output logic     valid,
   output rx_char_t head,
   output logic     head_ovr
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_fifo: DEPTH must be a power of two, at least 2");
   end

   localparam int PW   = $clog2(DEPTH);
   localparam int CNTW = PW + 1;
   localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

   rx_char_t        mem_q [DEPTH];
   logic [DEPTH-1:0] ovr_q;
   logic [PW-1:0]   wp_q, rp_q, wp_last;
   logic [CNTW-1:0] cnt_q;
   logic            full, empty, do_pop, do_push;

   assign full    = (cnt_q == FULL_CNT);
   assign empty   = (cnt_q == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign wp_last = wp_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         ovr_q <= '0;
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) begin
            mem_q[wp_q] <= wdata;
            ovr_q[wp_q] <= 1'b0;
            wp_q        <= wp_q + 1'b1;
         end else if (push) begin
            ovr_q[wp_last] <= 1'b1;
         end
         if (do_pop) rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + CNTW'(do_push) - CNTW'(do_pop);
      end
   end

   assign valid    = !empty;
   assign head     = empty ? '0 : mem_q[rp_q];
   assign head_ovr = !empty && ovr_q[rp_q];

   // R7: occupancy never exceeds the queue depth
   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   // R7: a pop without a push removes exactly one entry
   p_pop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && valid && !push) |=> cnt_q == $past(cnt_q) - 1'b1);

   // R8: a push into a full queue keeps it full and marks the newest entry
   p_overrun_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (full && ovr_q[wp_last] && $stable(rp_q)));
endmodule

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo import uart_rx_pkg::*; #(
   parameter int DEPTH       = 2,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int OVS         = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             sync_mode,
   input  logic             sclk_edge_sel,
   input  logic             sclk_in,
   input  logic             rxd_in,
   input  logic [2:0]       char_size,
   input  logic [1:0]       parity_mode,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             rd_pop,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             rd_bit9,
   output logic             rd_frame_err,
   output logic             rd_parity_err,
   output logic             rd_overrun
);
   logic [1:0] pins_s;
   logic       line, sclk_s, sclk_d;
   logic       tick, strobe, rise, fall;
   logic       push;
   rx_char_t   char_w, head;

   uart_rx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({sclk_in, rxd_in}),
      .dout (pins_s)
   );
   assign line   = pins_s[0];
   assign sclk_s = pins_s[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk_s;
   end
   assign rise   = sclk_s & ~sclk_d;
   assign fall   = ~sclk_s & sclk_d;
   assign strobe = sync_mode && (sclk_edge_sel ? fall : rise);

   uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (rx_en && !sync_mode),
      .div  (baud_div),
      .tick (tick)
   );

   uart_rx_frame #(.OVS(OVS)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (rx_en),
      .sync_mode  (sync_mode),
      .tick       (tick),
      .strobe     (strobe),
      .line       (line),
      .char_size  (char_size),
      .parity_mode(parity_mode),
      .push       (push),
      .char_o     (char_w)
   );

   uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wdata   (char_w),
      .pop     (rd_pop),
      .valid   (rd_valid),
      .head    (head),
      .head_ovr(rd_overrun)
   );

   assign rd_data       = head.data;
   assign rd_bit9       = head.bit9;
   assign rd_frame_err  = head.ferr;
   assign rd_parity_err = head.perr;

   // R9: only one sampling edge kind is ever taken in synchronous mode
   p_one_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (sclk_edge_sel ? !sclk_s : sclk_s));

   // R11: the queue is empty and reads zero on the first cycle after reset
   p_reset_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rd_valid && rd_data == 8'h00));
endmodule

// File: tb/uart_rx_status_fifo_tb.sv
module uart_rx_status_fifo_tb_top;
   localparam int DEPTH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        sync_mode = 1'b0;
   logic        sclk_edge_sel = 1'b0;
   logic        sclk_in = 1'b1;
   logic        rxd_in = 1'b1;
   logic [2:0]  char_size = 3'b011;
   logic [1:0]  parity_mode = 2'b00;
   logic [15:0] baud_div = 16'd3;
   logic        rd_pop = 1'b0;
   logic        rd_valid, rd_bit9, rd_frame_err, rd_parity_err, rd_overrun;
   logic [7:0]  rd_data;

   always #4 clk = ~clk;

   uart_rx_status_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_mode(sync_mode),
      .sclk_edge_sel(sclk_edge_sel), .sclk_in(sclk_in), .rxd_in(rxd_in),
      .char_size(char_size), .parity_mode(parity_mode), .baud_div(baud_div),
      .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit9(rd_bit9),
      .rd_frame_err(rd_frame_err), .rd_parity_err(rd_parity_err),
      .rd_overrun(rd_overrun)
   );

   typedef struct {
      logic [7:0] d;
      bit b9, fe, pe, ov;
   } exp_t;

   exp_t  q[$];
   int    checks = 0;
   int    errors = 0;
   bit    quiet = 1'b0;
   string cur_req = "R11";

   // reference queue compared every clock while nothing is in flight
   always @(negedge clk) begin
      if (quiet && rst_n) begin
         exp_t e;
         bit   ev;
         ev = (q.size() > 0);
         if (ev) e = q[0];
         else begin e.d = 8'h00; e.b9 = 0; e.fe = 0; e.pe = 0; e.ov = 0; end
         checks++;
         if (rd_valid !== ev || rd_data !== e.d || rd_bit9 !== e.b9 ||
             rd_frame_err !== e.fe || rd_parity_err !== e.pe || rd_overrun !== e.ov) begin
            errors++;
            $display("FAIL %s: got v=%0b d=%h b9=%0b fe=%0b pe=%0b ov=%0b exp v=%0b d=%h b9=%0b fe=%0b pe=%0b ov=%0b",
               cur_req, rd_valid, rd_data, rd_bit9, rd_frame_err, rd_parity_err, rd_overrun,
               ev, e.d, e.b9, e.fe, e.pe, e.ov);
         end
      end
   end

   task automatic model_push(input logic [7:0] d, input bit b9, input bit fe, input bit pe);
      exp_t e;
      if (q.size() == DEPTH) q[q.size()-1].ov = 1'b1;
      else begin
         e.d = d; e.b9 = b9; e.fe = fe; e.pe = pe; e.ov = 1'b0;
         q.push_back(e);
      end
   endtask

   task automatic do_pop();
      quiet = 1'b0;
      rd_pop = 1'b1;
      @(posedge clk); #1;
      rd_pop = 1'b0;
      if (q.size() > 0) void'(q.pop_front());
      quiet = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic hold(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // builds bit list: start, data LSB first, optional parity, stops
   task automatic build(input int nb, input logic [8:0] val, input logic [1:0] pm,
                        input bit flip_par, input bit stop_v, input int nstop,
                        output bit fr[32], output int n, output logic [7:0] d,
                        output bit b9, output bit pe);
      bit p;
      n = 0; p = 1'b0;
      fr[n++] = 1'b0;
      for (int i = 0; i < nb; i++) begin
         fr[n++] = val[i];
         p ^= val[i];
      end
      pe = 1'b0;
      if (pm[1]) begin
         fr[n++] = p ^ pm[0] ^ flip_par;
         pe = flip_par;
      end
      fr[n++] = stop_v;
      for (int i = 1; i < nstop; i++) fr[n++] = 1'b1;
      d = 8'h00;
      for (int i = 0; i < nb && i < 8; i++) d[i] = val[i];
      b9 = (nb == 9) ? val[8] : 1'b0;
   endtask

   task automatic send_async(input int nb, input logic [8:0] val, input logic [1:0] pm,
                             input bit flip_par, input bit stop_v, input int nstop);
      bit fr[32]; int n; logic [7:0] d; bit b9, pe; int blen;
      build(nb, val, pm, flip_par, stop_v, nstop, fr, n, d, b9, pe);
      blen = 16 * (int'(baud_div) + 1);
      quiet = 1'b0;
      for (int i = 0; i < n; i++) begin
         rxd_in = fr[i];
         hold(blen);
      end
      rxd_in = 1'b1;
      if (!stop_v) hold(2 * blen);
      if (rx_en) model_push(d, b9, !stop_v, pe);
      quiet = 1'b1;
      hold(4);
   endtask

   task automatic send_sync(input int nb, input logic [8:0] val, input logic [1:0] pm,
                            input bit flip_par);
      bit fr[32]; int n; logic [7:0] d; bit b9, pe; bit slvl;
      build(nb, val, pm, flip_par, 1'b1, 1, fr, n, d, b9, pe);
      slvl = !sclk_edge_sel;
      quiet = 1'b0;
      sclk_in = slvl;
      hold(8);
      for (int i = 0; i < n; i++) begin
         rxd_in = fr[i];
         sclk_in = !slvl;
         hold(8);
         sclk_in = slvl;
         hold(8);
      end
      rxd_in = 1'b1;
      hold(8);
      model_push(d, b9, 1'b0, pe);
      quiet = 1'b1;
      hold(4);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      hold(6);
      // R11: outputs during and right after reset
      checks++;
      if (rd_valid !== 1'b0 || rd_data !== 8'h00 || rd_overrun !== 1'b0) begin
         errors++;
         $display("FAIL R11: got v=%0b d=%h ov=%0b exp v=0 d=00 ov=0", rd_valid, rd_data, rd_overrun);
      end
      rst_n = 1'b1;
      rx_en = 1'b1;
      quiet = 1'b1;
      hold(20);

      cur_req = "R2";
      send_async(8, 9'h05A, 2'b00, 0, 1, 1); do_pop();
      baud_div = 16'd7; hold(4);
      send_async(8, 9'h0C3, 2'b00, 0, 1, 1); do_pop();
      baud_div = 16'd3; hold(4);

      cur_req = "R3";
      char_size = 3'b000; send_async(5, 9'h0F5, 2'b00, 0, 1, 1); do_pop();
      char_size = 3'b001; send_async(6, 9'h0EA, 2'b00, 0, 1, 1); do_pop();
      char_size = 3'b010; send_async(7, 9'h0B3, 2'b00, 0, 1, 1); do_pop();
      char_size = 3'b101; send_async(8, 9'h081, 2'b00, 0, 1, 1); do_pop();

      cur_req = "R4";
      char_size = 3'b111;
      send_async(9, 9'h1A5, 2'b00, 0, 1, 1); do_pop();
      send_async(9, 9'h03C, 2'b00, 0, 1, 1); do_pop();
      char_size = 3'b011;

      cur_req = "R5";
      parity_mode = 2'b10;
      send_async(8, 9'h037, 2'b10, 0, 1, 1);
      send_async(8, 9'h037, 2'b10, 1, 1, 1);
      do_pop(); do_pop();
      parity_mode = 2'b11;
      send_async(8, 9'h0F0, 2'b11, 0, 1, 1);
      send_async(8, 9'h0F0, 2'b11, 1, 1, 1);
      do_pop(); do_pop();
      parity_mode = 2'b01;
      send_async(8, 9'h066, 2'b01, 0, 1, 1); do_pop();
      parity_mode = 2'b00;

      cur_req = "R6";
      send_async(8, 9'h0AA, 2'b00, 0, 0, 1); do_pop();
      send_async(8, 9'h055, 2'b00, 0, 1, 2); do_pop();

      cur_req = "R1";
      rxd_in = 1'b0; hold(8); rxd_in = 1'b1; hold(200);
      send_async(8, 9'h011, 2'b00, 0, 1, 1); do_pop();

      cur_req = "R7";
      do_pop();
      send_async(8, 9'h0A1, 2'b00, 0, 0, 1);
      send_async(8, 9'h0B2, 2'b00, 0, 1, 1);
      do_pop(); do_pop(); do_pop();

      cur_req = "R8";
      send_async(8, 9'h0C1, 2'b00, 0, 1, 1);
      send_async(8, 9'h0C2, 2'b00, 0, 1, 1);
      send_async(8, 9'h0C3, 2'b00, 0, 1, 1);
      do_pop(); do_pop();

      cur_req = "R9";
      sync_mode = 1'b1; sclk_edge_sel = 1'b0; hold(8);
      send_sync(8, 9'h09C, 2'b00, 0); do_pop();
      sclk_edge_sel = 1'b1; sclk_in = 1'b0; hold(8);
      char_size = 3'b111; parity_mode = 2'b11;
      send_sync(9, 9'h14E, 2'b11, 1); do_pop();
      char_size = 3'b011; parity_mode = 2'b00;
      sync_mode = 1'b0; sclk_in = 1'b1; sclk_edge_sel = 1'b0; hold(8);

      cur_req = "R10";
      rx_en = 1'b0; hold(4);
      send_async(8, 9'h0E7, 2'b00, 0, 1, 1);
      rx_en = 1'b1; hold(40);
      send_async(8, 9'h07E, 2'b00, 0, 1, 1); do_pop();

      quiet = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule